// File: doc/BRIEF.md
# Boot Pushbutton Single-Press Detector

This block turns one raw boot pushbutton into a clean, one-cycle boot request. It samples the button only on a scan-line tick and counts for how many of those ticks the button stays down. When the button comes back up, the measured length is kept for later. A press that is too short is dropped as noise. A press that is too long is saved as a saturated "all ones" length, which means "do not boot".

A separate decision machine runs only on field ticks. It takes a saved press length, starts a quiet-wait countdown in fields, and records whether the press is allowed to boot. If the button stays up for the whole countdown and the press was allowed, the block raises a boot pulse for one cycle. A second press during the countdown restarts the wait and marks the action as ignore, so a burst of presses never produces a boot here.

All three thresholds are parameters counted in ticks: the shortest accepted press, the longest accepted press and the wait length.

Top module: `boot_press_filter`

## Requirements
- R1: After reset, `boot_o`, `wait_busy_o` and `armed_o` are all 0.
- R2: A press sampled down on fewer than MIN_LINES line ticks is discarded. No later field tick starts a wait for it, and `wait_busy_o` stays 0.
- R3: A press sampled down on N line ticks, with MIN_LINES <= N <= MAX_LINES, is followed by a release line tick. The first field tick after that release starts the wait: `wait_busy_o` becomes 1, and `armed_o` becomes 1 if no wait was already running.
- R4: The field tick that starts a wait is followed by further field ticks, all with the button up. The WAIT_FIELDS-th of these ends the wait. In the cycle after it, `wait_busy_o` and `armed_o` are 0, and `boot_o` is 1 for exactly one cycle if `armed_o` was 1. Field ticks between the start and the end leave `boot_o` at 0.
- R5: A press sampled down on more than MAX_LINES line ticks saturates the stored length at all ones (16'hFFFF). Its wait starts with `armed_o` = 0 and ends without a boot pulse. A stored length is always 0, all ones, or within [MIN_LINES, MAX_LINES].
- R6: A qualifying press that is released while a wait is running restarts the countdown at WAIT_FIELDS on the next field tick, with `armed_o` = 0. That wait then ends without a boot pulse.
- R7: A field tick that occurs while the last line-tick sample shows the button down changes nothing. A stored press is not consumed, and a running countdown neither advances nor ends.
- R8: `wait_busy_o` and `armed_o` change only in the cycle that follows a field tick. `armed_o` is 1 only while `wait_busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| button_i | input | 1 | Boot pushbutton level, 1 = pressed |
| line_tick_i | input | 1 | One-cycle scan-line strobe; the button is sampled on it |
| field_tick_i | input | 1 | One-cycle field strobe; the decision machine steps on it |
| boot_o | output | 1 | One-cycle boot request |
| wait_busy_o | output | 1 | Quiet-wait countdown running |
| armed_o | output | 1 | Pending action is boot (1) or ignore (0) |

## Verification
The checker watches these properties on every cycle:
- the boot pulse is a single cycle long;
- the boot pulse only follows an armed field tick;
- the outputs stay still between field ticks;
- a held button freezes the countdown;
- the stored press length never takes a value between the accepted range and saturation.

Some behaviour only the bench's scenarios can show:
- the exact press-length boundaries, covered by sweeping the press length across both thresholds;
- the exact field tick on which the pulse appears;
- the restart-and-disarm on a second press;
- a countdown that resumes after a filtered press made during the wait.

// File: rtl/boot_press_pkg.sv
package boot_press_pkg;
  localparam int DUR_W = 16;
  typedef logic [DUR_W-1:0] dur_t;
  localparam dur_t DUR_SAT = '1;

  // Count one more sampled-down line; stop one past the upper limit.
  function automatic dur_t run_step(dur_t run, dur_t hi);
    return (run > hi) ? run : run + dur_t'(1);
  endfunction

  // Length to store at release: 0 if too short, all ones if too long.
  function automatic dur_t settle_len(dur_t run, dur_t lo, dur_t hi);
    if (run < lo) return '0;
    if (run > hi) return DUR_SAT;
    return run;
  endfunction

  // A stored press may boot only if it was not too long and no wait is running.
  function automatic logic boot_allowed(dur_t len, logic busy);
    return (len != DUR_SAT) && !busy;
  endfunction
endpackage

// File: rtl/bp_line_meter.sv
module bp_line_meter
  import boot_press_pkg::*;
#(
  parameter int MIN_LINES = 211,
  parameter int MAX_LINES = 65000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick_i,
  input  logic button_i,
  input  logic consume_i,
  output logic held_o,
  output dur_t dur_o,
  output logic release_ev_o
);
  localparam dur_t LO = dur_t'(MIN_LINES);
  localparam dur_t HI = dur_t'(MAX_LINES);

  logic held_q;
  dur_t run_q;
  dur_t dur_q;

  assign release_ev_o = line_tick_i && held_q && !button_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      run_q  <= '0;
      dur_q  <= '0;
    end else begin
      if (consume_i) dur_q <= '0;
      if (line_tick_i) begin
        held_q <= button_i;
        if (button_i) run_q <= run_step(run_q, HI);
        else          run_q <= '0;
      end
      if (release_ev_o) begin
        if (settle_len(run_q, LO, HI) != '0) dur_q <= settle_len(run_q, LO, HI);
      end
    end
  end

  assign held_o = held_q;
  assign dur_o  = dur_q;
endmodule

// File: rtl/bp_field_decider.sv
module bp_field_decider
  import boot_press_pkg::*;
#(
  parameter int WAIT_FIELDS = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic field_tick_i,
  input  logic held_i,
  input  dur_t dur_i,
  output logic consume_o,
  output logic expire_o,
  output logic boot_o,
  output logic wait_busy_o,
  output logic armed_o
);
  localparam int WAIT_W = $clog2(WAIT_FIELDS + 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_FIELDS);

  logic [WAIT_W-1:0] cnt_q;
  logic              act_q;
  logic              boot_q;
  logic              step;

  assign step      = field_tick_i && !held_i;
  assign consume_o = step && (dur_i != '0);
  assign expire_o  = step && (dur_i == '0) && (cnt_q == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      boot_q <= expire_o && act_q;
      if (consume_o) begin
        cnt_q <= WAIT_LOAD;
        act_q <= boot_allowed(dur_i, cnt_q != '0);
      end else if (expire_o) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else if (step && cnt_q != '0) begin
        cnt_q <= cnt_q - WAIT_W'(1);
      end
    end
  end

  assign boot_o      = boot_q;
  assign wait_busy_o = (cnt_q != '0);
  assign armed_o     = act_q;
endmodule

// File: rtl/boot_press_filter.sv
module boot_press_filter
  import boot_press_pkg::*;
#(
  parameter int MIN_LINES   = 211,
  parameter int MAX_LINES   = 65000,
  parameter int WAIT_FIELDS = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic button_i,
  input  logic line_tick_i,
  input  logic field_tick_i,
  output logic boot_o,
  output logic wait_busy_o,
  output logic armed_o
);
  logic held_w;
  dur_t dur_w;
  logic consume_w;
  logic release_w;
  logic expire_w;

  bp_line_meter #(
    .MIN_LINES(MIN_LINES),
    .MAX_LINES(MAX_LINES)
  ) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_tick_i (line_tick_i),
    .button_i    (button_i),
    .consume_i   (consume_w),
    .held_o      (held_w),
    .dur_o       (dur_w),
    .release_ev_o(release_w)
  );

  bp_field_decider #(
    .WAIT_FIELDS(WAIT_FIELDS)
  ) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_tick_i(field_tick_i),
    .held_i      (held_w),
    .dur_i       (dur_w),
    .consume_o   (consume_w),
    .expire_o    (expire_w),
    .boot_o      (boot_o),
    .wait_busy_o (wait_busy_o),
    .armed_o     (armed_o)
  );
endmodule

// File: rtl/boot_press_checks.sv
module boot_press_checks
  import boot_press_pkg::*;
#(
  parameter int MIN_LINES = 211,
  parameter int MAX_LINES = 65000
) (
  input logic clk,
  input logic rst_n,
  input logic field_tick_i,
  input logic held,
  input dur_t dur,
  input logic boot_o,
  input logic wait_busy_o,
  input logic armed_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !boot_o && !wait_busy_o && !armed_o);

  assert_armed_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |-> wait_busy_o);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_o |=> !boot_o);

  assert_pulse_from_armed_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_o |-> $past(field_tick_i) && $past(armed_o) && !wait_busy_o && !armed_o);

  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dur == '0) || (dur == DUR_SAT) ||
    ((dur >= dur_t'(MIN_LINES)) && (dur <= dur_t'(MAX_LINES))));

  assert_held_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_tick_i && held) |=> $stable(wait_busy_o) && $stable(armed_o) && !boot_o);

  assert_still_between_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_tick_i |=> $stable(wait_busy_o) && $stable(armed_o));
endmodule

bind boot_press_filter boot_press_checks #(
  .MIN_LINES(MIN_LINES),
  .MAX_LINES(MAX_LINES)
) i_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .field_tick_i(field_tick_i),
  .held        (held_w),
  .dur         (dur_w),
  .boot_o      (boot_o),
  .wait_busy_o (wait_busy_o),
  .armed_o     (armed_o)
);

// File: tb/test_boot_press_filter.sv
`timescale 1ns/1ps
module test_boot_press_filter;
  localparam int MINL = 3;
  localparam int MAXL = 10;
  localparam int WAITF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic button = 1'b0;
  logic line_tick = 1'b0;
  logic field_tick = 1'b0;
  logic boot, busy, armed;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boot_press_filter #(
    .MIN_LINES(MINL),
    .MAX_LINES(MAXL),
    .WAIT_FIELDS(WAITF)
  ) i_boot_press_filter (
    .clk(clk), .rst_n(rst_n), .button_i(button),
    .line_tick_i(line_tick), .field_tick_i(field_tick),
    .boot_o(boot), .wait_busy_o(busy), .armed_o(armed)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; button = 1'b0; line_tick = 1'b0; field_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic line_pulse();
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
  endtask

  task automatic field_pulse();
    @(negedge clk) field_tick = 1'b1;
    @(negedge clk) field_tick = 1'b0;
  endtask

  task automatic press(int n);
    @(negedge clk) button = 1'b1;
    for (int i = 0; i < n; i++) line_pulse();
  endtask

  task automatic release_btn();
    @(negedge clk) button = 1'b0;
    line_pulse();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 boot", boot, 0);
    chk("R1 busy", busy, 0);
    chk("R1 armed", armed, 0);

    // Sweep press length across both thresholds (R2 R3 R4 R5)
    for (int n = 0; n <= MAXL + 3; n++) begin
      automatic bit ok = (n >= MINL) && (n <= MAXL);
      automatic bit seen = (n >= MINL);
      do_reset();
      press(n);
      release_btn();
      for (int f = 1; f <= WAITF + 2; f++) begin
        field_pulse();
        if (!seen) begin
          chk("R2 busy", busy, 0);
          chk("R2 boot", boot, 0);
        end else if (f == 1) begin
          chk("R3 busy", busy, 1);
          chk(ok ? "R3 armed" : "R5 armed", armed, ok ? 1 : 0);
          chk("R4 boot", boot, 0);
        end else if (f <= WAITF) begin
          chk("R4 busy", busy, 1);
          chk("R4 boot", boot, 0);
        end else if (f == WAITF + 1) begin
          chk(ok ? "R4 boot" : "R5 boot", boot, ok ? 1 : 0);
          chk("R4 busy end", busy, 0);
          chk("R4 armed end", armed, 0);
          @(negedge clk);
          chk("R4 pulse width", boot, 0);
        end else begin
          chk("R4 boot after", boot, 0);
          chk("R4 busy after", busy, 0);
        end
      end
    end

    // R7: field tick during a press does not consume it; R6 restart disarms
    do_reset();
    press(5);
    field_pulse();
    chk("R7 not consumed while held", busy, 0);
    release_btn();
    field_pulse();
    chk("R3 armed", armed, 1);
    field_pulse();
    field_pulse();
    press(5);
    field_pulse();
    chk("R7 busy held", busy, 1);
    chk("R7 armed held", armed, 1);
    release_btn();
    field_pulse();
    chk("R6 busy restart", busy, 1);
    chk("R6 armed cleared", armed, 0);
    for (int f = 1; f <= WAITF; f++) begin
      field_pulse();
      chk("R6 no boot", boot, 0);
      chk("R6 busy", busy, (f < WAITF) ? 1 : 0);
    end

    // R7: held button freezes countdown; a filtered press resumes it
    do_reset();
    press(5);
    release_btn();
    field_pulse();
    press(MINL - 1);
    for (int f = 0; f < 6; f++) begin
      field_pulse();
      chk("R7 frozen busy", busy, 1);
      chk("R7 frozen boot", boot, 0);
    end
    release_btn();
    for (int f = 1; f <= WAITF; f++) begin
      field_pulse();
      chk("R7 resume boot", boot, (f == WAITF) ? 1 : 0);
      chk("R8 armed follows busy", armed, (f < WAITF) ? 1 : 0);
    end

    // R8: line ticks alone never move the decision outputs
    do_reset();
    press(5);
    release_btn();
    for (int i = 0; i < 5; i++) line_pulse();
    chk("R8 busy no field", busy, 0);
    chk("R8 armed no field", armed, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule